// File: doc/BRIEF.md
# Frame CRC Generator with In-Stream Insertion

This block sits in a transmit word path ahead of the line encoder. Each word is 32 bits of data plus a K flag that marks the most significant character as a control character. When CRC handling is enabled, the block finds frame starts on its own by decoding ordered sets. It builds a 32-bit CRC over the data words of the frame. When the frame closes with an end-of-frame ordered set, it writes the finished value into the word slot that the sender reserved directly before that end-of-frame. A second enable lets IDLE ordered sets appear inside a frame. These IDLE words pause the frame, and the CRC ignores them.

Words enter and leave on valid/ready streams. The block holds one word internally. An accepted word is released to the output register only when the following word is accepted, because only the following word shows whether the held word is the reserved CRC slot. The input side is ready whenever the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no input is accepted. The source must keep the stream moving, for example with IDLE words between frames, so that the last word is pushed out.

Top module: `frame_crc_inserter`

## Requirements
- R1: Every accepted word appears on the output, in order, in the output-register cycle after the next word is accepted. `out_valid` rises on the edge that accepts that next word.
- R2: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_k` and `out_data` stay unchanged on the following edge.
- R3: Word decoding works as follows.
  - An ordered set is a word with K=1 and bits [31:24] equal to 0xBC.
  - The IDLE word is exactly 0xBC95B5B5.
  - Any other ordered set with bits [23:16] equal to 0xB5 is a start-of-frame.
  - Any other ordered set with bits [23:16] equal to 0x95 or 0xF5 is an end-of-frame.
  - Any remaining ordered set is an "other" ordered set.
  - A word with K=0 is a data word.
- R4: While `crc_en` is low, every word passes unaltered and any open frame is closed.
- R5: CRC generation and insertion.
  - The CRC is accumulated only between a start-of-frame and the close of that frame. The start-of-frame word itself is not included.
  - At the start-of-frame the register is preset to 0xFFFFFFFF. Each data word of the frame is then folded in with polynomial 0x04C11DB7, most significant byte first and MSB-first within each byte.
  - Insertion needs a data word of the frame directly followed by an end-of-frame, with `crc_en` high when the end-of-frame is accepted. That data word is then output as the bitwise complement of the register over all earlier frame data words, with K=0.
- R6: Ordered sets, and words with K=1, always leave the block unaltered. `out_k` always equals the K flag of the word being output.
- R7: With `idle_skip_en` high, an IDLE inside a frame leaves the frame open and is not folded into the CRC. An IDLE placed between the reserved slot and the end-of-frame prevents insertion.
- R8: With `idle_skip_en` low, an IDLE inside a frame closes the frame. A later end-of-frame inserts nothing.
- R9: An "other" ordered set closes the frame. A later end-of-frame inserts nothing.
- R10: A start-of-frame arriving inside an open frame restarts the frame and re-presets the CRC.
- R11: After reset, `out_valid` is low, `in_ready` is high, no word is held, and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | Enables frame detection and CRC insertion |
| idle_skip_en | input | 1 | Lets IDLE words sit inside a frame without affecting the CRC |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept the input word |
| in_k | input | 1 | Control-character flag of the most significant byte |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_k | output | 1 | Control-character flag of the output word |
| out_data | output | 32 | Output word, possibly replaced by the CRC |

## Verification
The assertions assume the downstream side follows the valid/ready rules of R2. They also assume `crc_en` is stable whenever a word is accepted, because the checker relates only accepted words to the word that leaves one transfer later. The stimulus changes `crc_en` and `idle_skip_en` only together with a new word. It applies a stall pattern on `out_ready` that never depends on the output contents, so every word is eventually drained. Each table entry says whether a word passes, is folded into the CRC, presets it, or must come back as the CRC. The bench therefore derives expected CRC values from the entries with its own byte-wise reference computation.

// File: rtl/fci_pkg.sv
package fci_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [7:0]        OS_CODE_DEF    = 8'hBC;
  localparam logic [7:0]        SOF_CODE_DEF   = 8'hB5;
  localparam logic [7:0]        EOF_CODE_A_DEF = 8'h95;
  localparam logic [7:0]        EOF_CODE_B_DEF = 8'hF5;
  localparam logic [WORD_W-1:0] IDLE_WORD_DEF  = 32'hBC95_B5B5;
  localparam logic [WORD_W-1:0] POLY_DEF       = 32'h04C1_1DB7;
  localparam logic [WORD_W-1:0] INIT_DEF       = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    WC_DATA,
    WC_CTRL,
    WC_SOF,
    WC_IDLE,
    WC_EOF,
    WC_OTHER_OS
  } wclass_e;

  typedef struct packed {
    logic              k;
    logic [WORD_W-1:0] data;
  } txword_t;

endpackage

// File: rtl/fci_classify.sv
module fci_classify
  import fci_pkg::*;
#(
  parameter int unsigned W          = WORD_W,
  parameter logic [7:0]  OS_CODE    = OS_CODE_DEF,
  parameter logic [7:0]  SOF_CODE   = SOF_CODE_DEF,
  parameter logic [7:0]  EOF_CODE_A = EOF_CODE_A_DEF,
  parameter logic [7:0]  EOF_CODE_B = EOF_CODE_B_DEF,
  parameter logic [W-1:0] IDLE_WORD = IDLE_WORD_DEF
) (
  input  logic         k,
  input  logic [W-1:0] data,
  output wclass_e      cls
);
  localparam int unsigned TOP_LSB = W - 8;
  localparam int unsigned SUB_LSB = W - 16;

  logic [7:0] top_byte;
  logic [7:0] sub_byte;

  assign top_byte = data[TOP_LSB +: 8];
  assign sub_byte = data[SUB_LSB +: 8];

  always_comb begin
    if (!k) begin
      cls = WC_DATA;
    end else if (top_byte != OS_CODE) begin
      cls = WC_CTRL;
    end else if (data == IDLE_WORD) begin
      cls = WC_IDLE;
    end else if (sub_byte == SOF_CODE) begin
      cls = WC_SOF;
    end else if (sub_byte == EOF_CODE_A || sub_byte == EOF_CODE_B) begin
      cls = WC_EOF;
    end else begin
      cls = WC_OTHER_OS;
    end
  end

endmodule

// File: rtl/fci_frame_ctl.sv
module fci_frame_ctl
  import fci_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv,
  input  wclass_e cls,
  input  logic    crc_en,
  input  logic    idle_skip_en,
  output logic    frame_data,
  output logic    sof_start
);
  logic in_frame;
  logic in_frame_nxt;

  always_comb begin
    in_frame_nxt = in_frame;
    frame_data   = 1'b0;
    sof_start    = 1'b0;
    if (!crc_en) begin
      in_frame_nxt = 1'b0;
    end else begin
      unique case (cls)
        WC_SOF: begin
          in_frame_nxt = 1'b1;
          sof_start    = 1'b1;
        end
        WC_DATA: frame_data = in_frame;
        WC_IDLE: begin
          if (!idle_skip_en) in_frame_nxt = 1'b0;
        end
        WC_EOF,
        WC_OTHER_OS: in_frame_nxt = 1'b0;
        WC_CTRL: in_frame_nxt = in_frame;
        default: in_frame_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
    end else if (adv) begin
      in_frame <= in_frame_nxt;
    end
  end

endmodule

// File: rtl/fci_crc_acc.sv
module fci_crc_acc
  import fci_pkg::*;
#(
  parameter int unsigned  W    = WORD_W,
  parameter logic [W-1:0] POLY = POLY_DEF,
  parameter logic [W-1:0] INIT = INIT_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset,
  input  logic         update,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc_q
);
  logic [W-1:0] crc_nxt;

  always_comb begin
    logic fb;
    crc_nxt = crc_q;
    for (int i = W - 1; i >= 0; i--) begin
      fb      = crc_nxt[W-1] ^ din[i];
      crc_nxt = {crc_nxt[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else if (preset) begin
      crc_q <= INIT;
    end else if (update) begin
      crc_q <= crc_nxt;
    end
  end

endmodule

// File: rtl/frame_crc_inserter.sv
module frame_crc_inserter
  import fci_pkg::*;
#(
  parameter int unsigned  W          = WORD_W,
  parameter logic [W-1:0] POLY       = POLY_DEF,
  parameter logic [W-1:0] INIT       = INIT_DEF,
  parameter logic [7:0]   OS_CODE    = OS_CODE_DEF,
  parameter logic [7:0]   SOF_CODE   = SOF_CODE_DEF,
  parameter logic [7:0]   EOF_CODE_A = EOF_CODE_A_DEF,
  parameter logic [7:0]   EOF_CODE_B = EOF_CODE_B_DEF,
  parameter logic [W-1:0] IDLE_WORD  = IDLE_WORD_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         crc_en,
  input  logic         idle_skip_en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_k,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_k,
  output logic [W-1:0] out_data
);
  wclass_e      in_cls;
  logic         adv;
  logic         fd_in;
  logic         sof_start;
  logic         hold_vld;
  logic         hold_fd;
  logic         hold_k;
  logic [W-1:0] hold_data;
  logic         insert;
  logic [W-1:0] crc_q;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;

  fci_classify #(
    .W(W), .OS_CODE(OS_CODE), .SOF_CODE(SOF_CODE),
    .EOF_CODE_A(EOF_CODE_A), .EOF_CODE_B(EOF_CODE_B), .IDLE_WORD(IDLE_WORD)
  ) u_cls (
    .k    (in_k),
    .data (in_data),
    .cls  (in_cls)
  );

  fci_frame_ctl u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv          (adv),
    .cls          (in_cls),
    .crc_en       (crc_en),
    .idle_skip_en (idle_skip_en),
    .frame_data   (fd_in),
    .sof_start    (sof_start)
  );

  fci_crc_acc #(.W(W), .POLY(POLY), .INIT(INIT)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .preset (adv && sof_start),
    .update (adv && hold_vld && hold_fd),
    .din    (hold_data),
    .crc_q  (crc_q)
  );

  assign insert = hold_vld && hold_fd && crc_en && (in_cls == WC_EOF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_fd   <= 1'b0;
      hold_k    <= 1'b0;
      hold_data <= '0;
      out_valid <= 1'b0;
      out_k     <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      hold_vld  <= 1'b1;
      hold_fd   <= fd_in;
      hold_k    <= in_k;
      hold_data <= in_data;
      out_valid <= hold_vld;
      out_k     <= hold_k;
      out_data  <= insert ? ~crc_q : hold_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fci_chk.sv
module fci_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         crc_en,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_k,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_k,
  input logic [W-1:0] out_data
);
  logic         acc;
  logic         sh_vld;
  logic         sh_k;
  logic [W-1:0] sh_data;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_vld  <= 1'b0;
      sh_k    <= 1'b0;
      sh_data <= '0;
    end else if (acc) begin
      sh_vld  <= 1'b1;
      sh_k    <= in_k;
      sh_data <= in_data;
    end
  end

  // R1: the previously accepted word is presented when the next word enters
  a_r1_word_released: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sh_vld |=> out_valid);

  // R2: output word frozen while stalled
  a_r2_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_k) && $stable(out_data));

  // R2: empty output register never blocks the input
  a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R4: nothing is altered while CRC handling is off
  a_r4_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sh_vld && !crc_en |=> out_data == $past(sh_data));

  // R6: K flag always follows its word
  a_r6_k_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sh_vld |=> out_k == $past(sh_k));

  // R6: control-flagged words are never rewritten
  a_r6_ctrl_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    acc && sh_vld && sh_k |=> out_data == $past(sh_data));

endmodule

bind frame_crc_inserter fci_chk #(.W(W)) u_fci_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .crc_en    (crc_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_k      (in_k),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_k     (out_k),
  .out_data  (out_data)
);

// File: tb/frame_crc_inserter_tb_top.sv
`timescale 1ns/1ps
module frame_crc_inserter_tb_top;

  // entry: [40:37] requirement, [36] crc_en, [35] idle skip, [34] K, [33:2] data, [1:0] tag
  // tag 0 = passes unchanged, 1 = passes and is folded into CRC,
  // tag 2 = must come back as complemented CRC, 3 = passes and presets CRC
  localparam int NV = 47;
  localparam logic [40:0] VEC [NV] = '{
    // R5: plain frame, CRC in slot before end-of-frame
    {4'd5, 2'b10, 1'b1, 32'hBC95_B5B5, 2'd0},
    {4'd5, 2'b10, 1'b1, 32'hBCB5_5656, 2'd3},
    {4'd5, 2'b10, 1'b0, 32'h1122_3344, 2'd1},
    {4'd5, 2'b10, 1'b0, 32'hDEAD_BEEF, 2'd1},
    {4'd5, 2'b10, 1'b0, 32'h0000_0000, 2'd2},
    {4'd6, 2'b10, 1'b1, 32'hBC95_D5D5, 2'd0},
    {4'd6, 2'b10, 1'b1, 32'hBC95_B5B5, 2'd0},
    // R7: idles inside frame skipped; R3: second end-of-frame code
    {4'd7, 2'b11, 1'b1, 32'hBCB5_5656, 2'd3},
    {4'd7, 2'b11, 1'b0, 32'hCAFE_F00D, 2'd1},
    {4'd7, 2'b11, 1'b1, 32'hBC95_B5B5, 2'd0},
    {4'd7, 2'b11, 1'b1, 32'hBC95_B5B5, 2'd0},
    {4'd7, 2'b11, 1'b0, 32'h1234_5678, 2'd1},
    {4'd7, 2'b11, 1'b0, 32'hFFFF_FFFF, 2'd2},
    {4'd3, 2'b11, 1'b1, 32'hBCF5_1515, 2'd0},
    {4'd3, 2'b11, 1'b1, 32'hBC95_B5B5, 2'd0},
    // R8: idle without skip closes frame
    {4'd8, 2'b10, 1'b1, 32'hBCB5_5656, 2'd3},
    {4'd8, 2'b10, 1'b0, 32'hA5A5_A5A5, 2'd0},
    {4'd8, 2'b10, 1'b1, 32'hBC95_B5B5, 2'd0},
    {4'd8, 2'b10, 1'b0, 32'h5A5A_5A5A, 2'd0},
    {4'd8, 2'b10, 1'b1, 32'hBC95_D5D5, 2'd0},
    // R9: other ordered set closes frame
    {4'd9, 2'b10, 1'b1, 32'hBCB5_5656, 2'd3},
    {4'd9, 2'b10, 1'b0, 32'h0102_0304, 2'd0},
    {4'd9, 2'b10, 1'b0, 32'h0BAD_F00D, 2'd0},
    {4'd9, 2'b10, 1'b1, 32'hBC55_4A4A, 2'd0},
    {4'd9, 2'b10, 1'b0, 32'h7777_7777, 2'd0},
    {4'd9, 2'b10, 1'b1, 32'hBC95_D5D5, 2'd0},
    // R4: CRC handling off
    {4'd4, 2'b00, 1'b1, 32'hBCB5_5656, 2'd0},
    {4'd4, 2'b00, 1'b0, 32'h1357_2468, 2'd0},
    {4'd4, 2'b00, 1'b0, 32'h0000_0000, 2'd0},
    {4'd4, 2'b00, 1'b1, 32'hBC95_D5D5, 2'd0},
    // R10: restart inside frame; R3: K word that is not an ordered set
    {4'd10, 2'b10, 1'b1, 32'hBCB5_5656, 2'd3},
    {4'd10, 2'b10, 1'b0, 32'h9999_9999, 2'd0},
    {4'd10, 2'b10, 1'b1, 32'hBCB5_5656, 2'd3},
    {4'd10, 2'b10, 1'b0, 32'h1020_3040, 2'd1},
    {4'd3,  2'b10, 1'b1, 32'h3C00_0000, 2'd0},
    {4'd10, 2'b10, 1'b0, 32'h5060_7080, 2'd1},
    {4'd10, 2'b10, 1'b0, 32'h0000_0000, 2'd2},
    {4'd10, 2'b10, 1'b1, 32'hBC95_D5D5, 2'd0},
    // R5: empty frame, slot receives complement of preset = 0
    {4'd5, 2'b10, 1'b1, 32'hBCB5_5656, 2'd3},
    {4'd5, 2'b10, 1'b0, 32'hDEAD_DEAD, 2'd2},
    {4'd5, 2'b10, 1'b1, 32'hBC95_D5D5, 2'd0},
    {4'd5, 2'b10, 1'b1, 32'hBC95_B5B5, 2'd0},
    // R7: idle between slot and end-of-frame blocks insertion
    {4'd7, 2'b11, 1'b1, 32'hBCB5_5656, 2'd3},
    {4'd7, 2'b11, 1'b0, 32'h1111_1111, 2'd0},
    {4'd7, 2'b11, 1'b1, 32'hBC95_B5B5, 2'd0},
    {4'd7, 2'b11, 1'b1, 32'hBC95_D5D5, 2'd0},
    {4'd1, 2'b10, 1'b1, 32'hBC95_B5B5, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crc_en = 1'b0;
  logic        idle_skip_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_k = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_k;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic [40:0] expq [0:255];
  int wr = 0;
  int rd = 0;
  logic [31:0] bcrc = 32'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  frame_crc_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .idle_skip_en(idle_skip_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_k(in_k), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_k(out_k), .out_data(out_data)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 3; b >= 0; b--) begin
      r = r ^ {d[b*8 +: 8], 24'h0};
      for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ 32'h04C1_1DB7) : (r << 1);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual k=%0b data=%08h expected k=%0b data=%08h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic monitor();
    logic [40:0] e;
    logic [31:0] ed;
    if (out_valid && out_ready) begin
      if (rd >= wr) begin
        check("R1 unexpected word", {out_k, out_data}, 33'h0);
      end else begin
        e = expq[rd];
        rd++;
        ed = (e[1:0] == 2'd2) ? ~bcrc : e[33:2];
        check($sformatf("R%0d vector %0d", e[40:37], rd - 1), {out_k, out_data}, {e[34], ed});
        if (e[1:0] == 2'd3) bcrc = 32'hFFFF_FFFF;
        else if (e[1:0] == 2'd1) bcrc = ref_crc(bcrc, e[33:2]);
      end
    end
  endtask

  task automatic send(input logic [40:0] e);
    bit accepted = 0;
    while (!accepted) begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 7) != 5;
      in_valid = 1'b1;
      crc_en = e[36];
      idle_skip_en = e[35];
      in_k = e[34];
      in_data = e[33:2];
      #1;
      monitor();
      if (in_ready) begin
        accepted = 1;
        expq[wr] = e;
        wr++;
      end
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b1;
      #1;
      monitor();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual run incomplete expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 reset out_valid", {1'b0, 31'h0, out_valid}, 33'h0);
    check("R11 reset in_ready", {1'b0, 31'h0, in_ready}, 33'h1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) send(VEC[i]);
    drain(4);
    // R1: exactly the last word stays held
    check("R1 held word count", {1'b0, 32'(wr - rd)}, 33'd1);

    // R2: stall holds the output word and blocks the input
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; crc_en = 1'b1; idle_skip_en = 1'b0; in_k = 1'b1; in_data = 32'hBC95_B5B5;
    #1;
    check("R2 ready while output empty", {1'b0, 31'h0, in_ready}, 33'h1);
    expq[wr] = {4'd2, 2'b10, 1'b1, 32'hBC95_B5B5, 2'd0};
    wr++;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_data = 32'hBC95_B5B5;
      #1;
      check("R2 stalled ready low", {1'b0, 31'h0, in_ready}, 33'h0);
      check("R2 stalled word stable", {out_valid & out_k, out_data}, {1'b1, 32'hBC95_B5B5});
    end
    drain(3);

    // R11: reset in mid-frame leaves no open frame
    send({4'd11, 2'b10, 1'b1, 32'hBCB5_5656, 2'd3});
    send({4'd11, 2'b10, 1'b0, 32'h2468_ACE0, 2'd1});
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11 reset clears output", {1'b0, 31'h0, out_valid}, 33'h0);
    rd = wr;
    @(negedge clk);
    rst_n = 1'b1;
    send({4'd11, 2'b10, 1'b0, 32'h0F0F_0F0F, 2'd0});
    send({4'd11, 2'b10, 1'b1, 32'hBC95_D5D5, 2'd0});
    send({4'd11, 2'b10, 1'b1, 32'hBC95_B5B5, 2'd0});
    drain(4);
    check("R11 words after reset", {1'b0, 32'(wr - rd)}, 33'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule